// File: doc/BRIEF.md
# Byte-Granular Access Window for a Word-Wide SRAM

This block lets an 8-bit microcontroller read and write single bytes of a 32-bit-wide SRAM. The controller sees three registers: a data register and two 8-bit address registers. Together, the two address registers hold a 16-bit byte address. Bits 1:0 of that address pick a byte lane. The bits above them form the SRAM word address.

The SRAM is shared with other agents. This block may use it only while the slot strobe `slot_i` is high, one clock cycle per owned slot. In each owned slot the block normally reloads a 32-bit shadow latch from the addressed SRAM word. Register reads are served from that latch.

A write to the data register changes only the selected byte of the latch and marks a commit as pending. In the next owned slot, the whole latch is written back to the SRAM. While a commit is pending, refresh reads stop, so a merged byte can never be overwritten before it reaches the memory.

All register and memory pins are plain single-cycle signals. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. A register write is accepted in the cycle where `reg_wr_i` is high. A read result is combinational from `reg_sel_i` and the current state.

Top module: `sram_byte_window`

## Requirements
- R1: After reset, both address registers read 0, the data register reads 0, no commit is pending, and `mem_we_o` stays low until a data write has been made.
- R2: In an owned slot with no commit pending and no data write in the same cycle, the latch takes `mem_rdata_i` at the clock edge that ends the slot.
- R3: A data-register read returns latch bits [8*k+7:8*k], where k is byte-address bits 1:0. Lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R4: A data-register write (`reg_sel_i` = 0) replaces only latch lane k with `reg_wdata_i`. The other three lanes keep their values.
- R5: After a data write, the next owned slot drives `mem_we_o` high with `mem_addr_o` equal to the current word address and `mem_wdata_o` equal to the full merged latch.
- R6: While a commit is pending, no refresh takes place, and that includes the commit slot itself. The latch keeps the merged data whatever `mem_rdata_i` holds.
- R7: Several data writes before a commit all merge into the latch, and exactly one SRAM write follows.
- R8: After the commit slot, each owned slot refreshes the latch from the SRAM again and issues no further write.
- R9: Select 1 writes and reads the low address register, and select 2 the high one. The word address on `mem_addr_o` is {high[7:0], low[7:2]}. Select 3 reads 0, and a write to it changes nothing.
- R10: A new address does not touch the latch. Its data appears only after the next owned slot's refresh. An address write made in a slot cycle still leaves that slot reading the old word.
- R11: A data write made in the commit slot itself is included in the committed word, and that slot clears the pending state.
- R12: A data write made in an owned slot with no commit pending suppresses that slot's refresh. The merged latch is committed in the following owned slot.
- R13: `mem_en_o` equals `slot_i`, and `mem_we_o` is never high outside an owned slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_i | input | 1 | High for the one cycle of an owned SRAM slot |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 data, 1 address low, 2 address high, 3 unused |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| mem_en_o | output | 1 | SRAM access enable |
| mem_we_o | output | 1 | SRAM write enable |
| mem_addr_o | output | 14 | SRAM word address |
| mem_wdata_o | output | 32 | SRAM write data |
| mem_rdata_i | input | 32 | SRAM read data for the addressed word, valid during the slot |

## Verification
The collisions of interest are a controller write landing in the same cycle as an owned slot.

A data write in a commit slot must be folded into the committed word. A data write in a refresh slot must win over the SRAM read and postpone the commit by one slot. An address write in a slot must leave that slot reading the old word.

Each case is driven by raising `slot_i` and `reg_wr_i` together. The bench changes the bench-side memory between steps, so a wrongly taken refresh shows up as foreign data. It judges each case from the logged SRAM write count, address and data, and from lane readback afterwards.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_ALO  = 2'd1,
    SEL_AHI  = 2'd2,
    SEL_NONE = 2'd3
  } sbw_sel_e;
endpackage

// File: rtl/sbw_addr_regs.sv
module sbw_addr_regs #(
  parameter int REG_W = 8,
  parameter int NREG  = 2,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [REG_W-1:0]      wr_data,
  output logic [REG_W*NREG-1:0] addr_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                 q <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))      q <= wr_data;
    end
    assign addr_o[g*REG_W +: REG_W] = q;
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(addr_o)); // R9
endmodule

// File: rtl/sbw_lane.sv
module sbw_lane #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int LSEL_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] latch_i,
  input  logic [LSEL_W-1:0] lane_i,
  input  logic [BYTE_W-1:0] wbyte_i,
  output logic [BYTE_W-1:0] rbyte_o,
  output logic [DATA_W-1:0] merged_o
);
  logic [LANES-1:0][BYTE_W-1:0] lanes;
  assign lanes   = latch_i;
  assign rbyte_o = lanes[lane_i];

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged_o[g*BYTE_W +: BYTE_W] =
      (lane_i == LSEL_W'(g)) ? wbyte_i : latch_i[g*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/sbw_ctrl.sv
module sbw_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_i,
  input  logic data_wr_i,
  output logic pending_o,
  output logic commit_o,
  output logic refresh_o
);
  logic pend_q;

  assign commit_o  = slot_i && pend_q;
  assign refresh_o = slot_i && !pend_q && !data_wr_i;
  assign pending_o = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (commit_o) pend_q <= 1'b0;
    else if (data_wr_i) pend_q <= 1'b1;
  end

  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && pend_q) |=> !pend_q); // R11
  AST_WRITE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_i && !(slot_i && pend_q)) |=> pend_q); // R12
  AST_PEND_WAITS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !slot_i) |=> pend_q); // R5
endmodule

// File: rtl/sram_byte_window.sv
module sram_byte_window
  import sbw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 8,
  parameter int NAREG  = 2,
  localparam int LANES  = DATA_W / REG_W,
  localparam int LSEL_W = $clog2(LANES),
  localparam int BADR_W = REG_W * NAREG,
  localparam int WADR_W = BADR_W - LSEL_W,
  localparam int IDX_W  = (NAREG > 1) ? $clog2(NAREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [WADR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  sbw_sel_e          sel;
  logic              data_wr, addr_wr;
  logic [IDX_W-1:0]  addr_idx;
  logic [BADR_W-1:0] byte_addr;
  logic [DATA_W-1:0] latch_q, merged;
  logic [REG_W-1:0]  lane_byte;
  logic              pending, commit, refresh;

  assign sel      = sbw_sel_e'(reg_sel_i);
  assign data_wr  = reg_wr_i && (sel == SEL_DATA);
  assign addr_wr  = reg_wr_i && (sel == SEL_ALO || sel == SEL_AHI);
  assign addr_idx = (sel == SEL_AHI) ? IDX_W'(1) : IDX_W'(0);

  sbw_addr_regs #(.REG_W(REG_W), .NREG(NAREG)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (addr_wr),
    .wr_idx  (addr_idx),
    .wr_data (reg_wdata_i),
    .addr_o  (byte_addr)
  );

  sbw_lane #(.DATA_W(DATA_W), .BYTE_W(REG_W)) u_lane (
    .latch_i  (latch_q),
    .lane_i   (byte_addr[LSEL_W-1:0]),
    .wbyte_i  (reg_wdata_i),
    .rbyte_o  (lane_byte),
    .merged_o (merged)
  );

  sbw_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_i    (slot_i),
    .data_wr_i (data_wr),
    .pending_o (pending),
    .commit_o  (commit),
    .refresh_o (refresh)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       latch_q <= '0;
    else if (data_wr) latch_q <= merged;
    else if (refresh) latch_q <= mem_rdata_i;
  end

  assign mem_en_o    = slot_i;
  assign mem_we_o    = commit;
  assign mem_addr_o  = byte_addr[BADR_W-1:LSEL_W];
  assign mem_wdata_o = data_wr ? merged : latch_q;

  always_comb begin
    case (sel)
      SEL_DATA: reg_rdata_o = lane_byte;
      SEL_ALO:  reg_rdata_o = byte_addr[REG_W-1:0];
      SEL_AHI:  reg_rdata_o = byte_addr[2*REG_W-1:REG_W];
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_REFRESH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && !pending && !data_wr) |=> latch_q == $past(mem_rdata_i)); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !data_wr) |=> $stable(latch_q)); // R6
  AST_WE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_en_o && slot_i)); // R13
endmodule

// File: tb/sim_sram_byte_window.sv
module sim_sram_byte_window;
  localparam logic [1:0] S_DATA = 2'd0, S_ALO = 2'd1, S_AHI = 2'd2, S_NONE = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_i = 1'b0, reg_wr_i = 1'b0;
  logic [1:0]  reg_sel_i = 2'd0;
  logic [7:0]  reg_wdata_i = 8'd0;
  logic [7:0]  reg_rdata_o;
  logic        mem_en_o, mem_we_o;
  logic [13:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;

  int checks = 0, errors = 0, cycles = 0;
  int we_cnt = 0, stray = 0;
  logic [13:0] last_addr = '0;
  logic [31:0] last_data = '0;
  logic [31:0] mem [int];

  always #2.5 clk = ~clk;

  sram_byte_window u0 (
    .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .reg_wr_i(reg_wr_i),
    .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  always_comb mem_rdata_i = mem.exists(int'(mem_addr_o)) ? mem[int'(mem_addr_o)] : 32'd0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n) begin
      if ((mem_en_o != slot_i) || (mem_we_o && !slot_i)) stray <= stray + 1;
      if (mem_we_o) begin
        mem[int'(mem_addr_o)] = mem_wdata_o;
        we_cnt    <= we_cnt + 1;
        last_addr <= mem_addr_o;
        last_data <= mem_wdata_o;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input bit s, input bit w, input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    slot_i = s; reg_wr_i = w; reg_sel_i = sel; reg_wdata_i = d;
    @(posedge clk); #1;
    slot_i = 1'b0; reg_wr_i = 1'b0;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [7:0] v);
    @(negedge clk);
    reg_sel_i = sel; #1;
    v = reg_rdata_o;
  endtask

  task automatic lane(input logic [7:0] lo, output logic [7:0] v);
    step(0, 1, S_ALO, lo);
    peek(S_DATA, v);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(S_DATA, v); chk("R1 data", 32'(v), 32'h0);
    peek(S_ALO, v);  chk("R1 alo", 32'(v), 32'h0);
    peek(S_AHI, v);  chk("R1 ahi", 32'(v), 32'h0);
    chk("R1 we", 32'(mem_we_o), 32'h0);
    step(1, 0, S_DATA, 8'h00);
    chk("R1 no write", 32'(we_cnt), 32'd0);
  endtask

  task automatic t_refresh();
    logic [7:0] v;
    mem[32'h105] = 32'hA1B2C3D4;
    step(0, 1, S_ALO, 8'h14);
    step(0, 1, S_AHI, 8'h04);
    peek(S_ALO, v); chk("R9 alo", 32'(v), 32'h14);
    peek(S_AHI, v); chk("R9 ahi", 32'(v), 32'h04);
    chk("R9 word", 32'(mem_addr_o), 32'h105);
    peek(S_DATA, v); chk("R10 before slot", 32'(v), 32'h0);
    step(1, 0, S_DATA, 8'h00);
    peek(S_DATA, v); chk("R2 lane0", 32'(v), 32'hD4);
    lane(8'h15, v); chk("R3 lane1", 32'(v), 32'hC3);
    lane(8'h16, v); chk("R3 lane2", 32'(v), 32'hB2);
    lane(8'h17, v); chk("R3 lane3", 32'(v), 32'hA1);
  endtask

  task automatic t_merge_commit();
    logic [7:0] v; int wc0;
    step(0, 1, S_ALO, 8'h16);
    step(0, 1, S_DATA, 8'h5E);
    peek(S_DATA, v); chk("R4 lane2", 32'(v), 32'h5E);
    lane(8'h14, v); chk("R4 lane0", 32'(v), 32'hD4);
    lane(8'h17, v); chk("R4 lane3", 32'(v), 32'hA1);
    chk("R5 no early write", 32'(we_cnt), 32'd0);
    mem[32'h105] = 32'h99999999;
    wc0 = we_cnt;
    step(1, 0, S_DATA, 8'h00);
    chk("R5 one write", 32'(we_cnt), 32'(wc0 + 1));
    chk("R5 addr", 32'(last_addr), 32'h105);
    chk("R5 data", last_data, 32'hA15EC3D4);
    lane(8'h14, v); chk("R6 no refresh in commit", 32'(v), 32'hD4);
    mem[32'h105] = 32'h0BADF00D;
    wc0 = we_cnt;
    step(1, 0, S_DATA, 8'h00);
    chk("R8 no rewrite", 32'(we_cnt), 32'(wc0));
    peek(S_DATA, v); chk("R8 refresh back", 32'(v), 32'h0D);
  endtask

  task automatic t_double();
    int wc0;
    step(0, 1, S_DATA, 8'h11);
    step(0, 1, S_ALO, 8'h17);
    step(0, 1, S_DATA, 8'h22);
    wc0 = we_cnt;
    step(1, 0, S_DATA, 8'h00);
    chk("R7 single write", 32'(we_cnt), 32'(wc0 + 1));
    chk("R7 data", last_data, 32'h22ADF011);
    step(1, 0, S_DATA, 8'h00);
    chk("R7 no second write", 32'(we_cnt), 32'(wc0 + 1));
  endtask

  task automatic t_collide_pend();
    int wc0;
    step(0, 1, S_ALO, 8'h15);
    step(0, 1, S_DATA, 8'h33);
    step(0, 1, S_ALO, 8'h16);
    wc0 = we_cnt;
    step(1, 1, S_DATA, 8'h44);
    chk("R11 commit", 32'(we_cnt), 32'(wc0 + 1));
    chk("R11 data", last_data, 32'h22443311);
    step(1, 0, S_DATA, 8'h00);
    chk("R11 cleared", 32'(we_cnt), 32'(wc0 + 1));
  endtask

  task automatic t_collide_fresh();
    logic [7:0] v; int wc0;
    mem[32'h105] = 32'hCAFEBABE;
    step(0, 1, S_ALO, 8'h14);
    wc0 = we_cnt;
    step(1, 1, S_DATA, 8'h55);
    chk("R12 no write", 32'(we_cnt), 32'(wc0));
    lane(8'h17, v); chk("R12 refresh skipped", 32'(v), 32'h22);
    step(1, 0, S_DATA, 8'h00);
    chk("R12 commit next", 32'(we_cnt), 32'(wc0 + 1));
    chk("R12 data", last_data, 32'h22443355);
  endtask

  task automatic t_addr_change();
    logic [7:0] v; int wc0;
    mem[32'h200] = 32'h76543210;
    step(1, 1, S_AHI, 8'h08);
    step(0, 1, S_ALO, 8'h00);
    chk("R9 new word", 32'(mem_addr_o), 32'h200);
    peek(S_DATA, v); chk("R10 old word kept", 32'(v), 32'h55);
    step(1, 0, S_DATA, 8'h00);
    peek(S_DATA, v); chk("R10 new word", 32'(v), 32'h10);
    wc0 = we_cnt;
    step(0, 1, S_NONE, 8'hFF);
    peek(S_NONE, v); chk("R9 sel3 reads 0", 32'(v), 32'h0);
    peek(S_ALO, v);  chk("R9 sel3 alo", 32'(v), 32'h00);
    peek(S_AHI, v);  chk("R9 sel3 ahi", 32'(v), 32'h08);
    peek(S_DATA, v); chk("R9 sel3 latch", 32'(v), 32'h10);
    step(1, 0, S_DATA, 8'h00);
    chk("R9 sel3 no commit", 32'(we_cnt), 32'(wc0));
    chk("R13 stray", 32'(stray), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_refresh();
    t_merge_commit();
    t_double();
    t_collide_pend();
    t_collide_fresh();
    t_addr_change();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 5000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule